// File: doc/BRIEF.md
# TLB Special Register Bank

This block is the register bank that software uses to manage a small translation lookaside buffer. Six registers are reachable through one request port. Each request carries a register number, a write enable, an upper-half flag and a 32-bit data word. The registers are a process identifier, a zone protection word, an index register, the two words of a TLB entry, and a search trigger. The TLB entries are never addressed directly. The low bits of the index register pick the entry, and reads and writes of the entry words go to that entry.

Reading or writing the entry tag word also moves the process identifier. A write copies the current identifier into the entry's stored identifier. A read loads the identifier register from the entry. A write to the search register starts a two-cycle lookup of the written address against all entries. The result goes into the index register. A configuration input sets how much of the bank software may use. Any request that is illegal, or that arrives while a search is running, returns zero and raises an error pulse.

Top module: `mmu_sreg_bank`

## Requirements
- R1: After reset, every register and every stored entry word and identifier is zero, so all entries are invalid. `err_o`, `busy_o` and `rdata_o` are low.
- R2: Register numbers are: 0 identifier, 1 zone word, 2 index, 3 entry data word, 4 entry tag word, 5 search, 6 and 7 unknown. Entry accesses use the entry selected by index bits [IDX_W-1:0]. Read data and `err_o` appear in the cycle after the request.
- R3: The entry data word is 64 bits wide. With `ext_i` high, an access to register 3 reads or writes bits 63:32, and with it low, bits 31:0. `ext_i` with any other register is an error.
- R4: A legal read of the tag word returns the selected entry's tag. It also loads the identifier register with that entry's stored identifier, zero-extended.
- R5: A legal write of the tag word stores the data as the entry's tag. It also stores identifier bits 7:0 as the entry's identifier.
- R6: A write to the index register updates only bits 30:0. Bit 31 is changed only by a search.
- R7: A search uses the written value with bits 9:0 cleared as the key. The tag layout is: page number 31:10, size code 9:7, valid 6. The page span is 1024 * 4^size. An entry matches when it is valid, the key and the tag agree above the span, and the stored identifier is zero or equal to identifier bits 7:0. The lowest matching index wins. On a hit the index register becomes that index with bit 31 clear. On a miss, bit 31 is set and bits 30:0 are kept.
- R8: `busy_o` is high for exactly the two cycles after an accepted search request. The index register holds the result once `busy_o` falls. Any request that arrives while `busy_o` is high is rejected.
- R9: Reading the search register is an error.
- R10: Access level 0 rejects every request. Writes to the identifier, the zone word and the search register need level bit 1. Reads of the zone word and of either entry word need level bit 0.
- R11: A rejected or unknown request returns zero read data and a one-cycle `err_o`, and changes no state. An accepted write returns zero read data and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tlb_lvl_i | input | 2 | Configured software access level |
| req_i | input | 1 | Register request strobe |
| we_i | input | 1 | Write when high, read when low |
| ext_i | input | 1 | Upper-half access flag |
| rnum_i | input | 3 | Register number |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| err_o | output | 1 | Rejected-access pulse |
| busy_o | output | 1 | Search in progress |

## Verification
Two events can fall in the same cycle: a search writing its result into the index register, and a software request that would read or write that register or the entries. The bench issues a request in the cycle right after each accepted search. It checks that the request is rejected with zero data, that `busy_o` stays high for exactly two cycles, and that the index register afterwards holds the value computed by the bench's own search function. Random traffic over all four access levels is checked against a bench model of the registers and entries.

// File: rtl/mmu_sreg_pkg.sv
`timescale 1ns/1ps
package mmu_sreg_pkg;
  localparam logic [2:0] RN_PID  = 3'd0;
  localparam logic [2:0] RN_ZPR  = 3'd1;
  localparam logic [2:0] RN_TLBX = 3'd2;
  localparam logic [2:0] RN_LO   = 3'd3;
  localparam logic [2:0] RN_HI   = 3'd4;
  localparam logic [2:0] RN_SX   = 3'd5;

  localparam int          VLD_BIT  = 6;
  localparam int          SZ_LSB   = 7;
  localparam logic [31:0] EPN_MASK = 32'hFFFF_FC00;
  localparam int          MISS_BIT = 31;

  typedef struct packed {
    logic legal;
    logic err;
    logic rd;
    logic wr_pid;
    logic wr_zpr;
    logic wr_tlbx;
    logic wr_lo;
    logic wr_hi;
    logic srch;
  } acc_t;

  function automatic logic [31:0] page_mask(input logic [2:0] sz);
    logic [31:0] span;
    span = 32'd1024 << {sz, 1'b0};
    return ~(span - 32'd1);
  endfunction
endpackage

// File: rtl/mmu_sreg_decode.sv
`timescale 1ns/1ps
module mmu_sreg_decode
  import mmu_sreg_pkg::*;
(
  input  logic       req_i,
  input  logic       busy_i,
  input  logic       we_i,
  input  logic       ext_i,
  input  logic [2:0] rnum_i,
  input  logic [1:0] lvl_i,
  output acc_t       acc_o
);
  logic ok;

  always_comb begin
    ok = 1'b0;
    if (req_i && !busy_i && lvl_i != 2'd0 && !(ext_i && rnum_i != RN_LO)) begin
      case (rnum_i)
        RN_PID:         ok = we_i ? lvl_i[1] : 1'b1;
        RN_ZPR:         ok = we_i ? lvl_i[1] : lvl_i[0];
        RN_TLBX:        ok = 1'b1;
        RN_LO, RN_HI:   ok = we_i ? 1'b1 : lvl_i[0];
        RN_SX:          ok = we_i ? lvl_i[1] : 1'b0;
        default:        ok = 1'b0;
      endcase
    end
  end

  always_comb begin
    acc_o         = '0;
    acc_o.legal   = ok;
    acc_o.err     = req_i && !ok;
    acc_o.rd      = ok && !we_i;
    acc_o.wr_pid  = ok && we_i && rnum_i == RN_PID;
    acc_o.wr_zpr  = ok && we_i && rnum_i == RN_ZPR;
    acc_o.wr_tlbx = ok && we_i && rnum_i == RN_TLBX;
    acc_o.wr_lo   = ok && we_i && rnum_i == RN_LO;
    acc_o.wr_hi   = ok && we_i && rnum_i == RN_HI;
    acc_o.srch    = ok && we_i && rnum_i == RN_SX;
  end
endmodule

// File: rtl/mmu_tlb_store.sv
`timescale 1ns/1ps
module mmu_tlb_store #(
  parameter int N_ENT = 8,
  localparam int IW   = $clog2(N_ENT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] idx_i,
  input  logic          wr_hi_i,
  input  logic          wr_lo_i,
  input  logic          ext_i,
  input  logic [31:0]   wdata_i,
  input  logic [7:0]    tid_i,
  output logic [31:0]   tag_o [N_ENT],
  output logic [63:0]   lo_o  [N_ENT],
  output logic [7:0]    tid_o [N_ENT]
);
  logic [31:0] tag_q [N_ENT];
  logic [63:0] lo_q  [N_ENT];
  logic [7:0]  tid_q [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic sel;
    assign sel = (idx_i == IW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[g] <= '0;
        lo_q[g]  <= '0;
        tid_q[g] <= '0;
      end else if (sel) begin
        if (wr_hi_i) begin
          tag_q[g] <= wdata_i;
          tid_q[g] <= tid_i;
        end
        if (wr_lo_i) begin
          if (ext_i) lo_q[g][63:32] <= wdata_i;
          else       lo_q[g][31:0]  <= wdata_i;
        end
      end
    end
    assign tag_o[g] = tag_q[g];
    assign lo_o[g]  = lo_q[g];
    assign tid_o[g] = tid_q[g];
  end
endmodule

// File: rtl/mmu_tlb_search.sv
`timescale 1ns/1ps
module mmu_tlb_search
  import mmu_sreg_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IW   = $clog2(N_ENT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [31:0]   key_i,
  input  logic [7:0]    pid_i,
  input  logic [31:0]   tag_i [N_ENT],
  input  logic [7:0]    tid_i [N_ENT],
  output logic          busy_o,
  output logic          done_o,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  logic             p1_q, p2_q;
  logic [31:0]      key_q;
  logic [7:0]       pid_q;
  logic [N_ENT-1:0] mv_d, mv_q;

  // stage 1: capture key and requester identifier
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_q  <= 1'b0;
      key_q <= '0;
      pid_q <= '0;
    end else begin
      p1_q <= start_i;
      if (start_i) begin
        key_q <= key_i & EPN_MASK;
        pid_q <= pid_i;
      end
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    logic [31:0] m;
    assign m       = page_mask(tag_i[g][SZ_LSB +: 3]);
    assign mv_d[g] = tag_i[g][VLD_BIT]
                   && ((key_q & m) == (tag_i[g] & EPN_MASK & m))
                   && (tid_i[g] == 8'd0 || tid_i[g] == pid_q);
  end

  // stage 2: registered match vector
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p2_q <= 1'b0;
      mv_q <= '0;
    end else begin
      p2_q <= p1_q;
      if (p1_q) mv_q <= mv_d;
    end
  end

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (mv_q[i]) idx_o = IW'(i);
    end
  end

  assign hit_o  = |mv_q;
  assign done_o = p2_q;
  assign busy_o = p1_q | p2_q;
endmodule

// File: rtl/mmu_sreg_bank.sv
`timescale 1ns/1ps
module mmu_sreg_bank
  import mmu_sreg_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IW   = $clog2(N_ENT)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  tlb_lvl_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic        ext_i,
  input  logic [2:0]  rnum_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        err_o,
  output logic        busy_o
);
  acc_t          acc;
  logic [31:0]   pid_q, zpr_q, tlbx_q, rdata_q;
  logic          err_q;
  logic [IW-1:0] sel;
  logic [31:0]   tag_w [N_ENT];
  logic [63:0]   lo_w  [N_ENT];
  logic [7:0]    tid_w [N_ENT];
  logic          srch_busy, srch_done, srch_hit;
  logic [IW-1:0] srch_idx;

  assign sel = tlbx_q[IW-1:0];

  mmu_sreg_decode u_dec (
    .req_i  (req_i),
    .busy_i (srch_busy),
    .we_i   (we_i),
    .ext_i  (ext_i),
    .rnum_i (rnum_i),
    .lvl_i  (tlb_lvl_i),
    .acc_o  (acc)
  );

  mmu_tlb_store #(.N_ENT(N_ENT)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_i   (sel),
    .wr_hi_i (acc.wr_hi),
    .wr_lo_i (acc.wr_lo),
    .ext_i   (ext_i),
    .wdata_i (wdata_i),
    .tid_i   (pid_q[7:0]),
    .tag_o   (tag_w),
    .lo_o    (lo_w),
    .tid_o   (tid_w)
  );

  mmu_tlb_search #(.N_ENT(N_ENT)) u_srch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (acc.srch),
    .key_i   (wdata_i),
    .pid_i   (pid_q[7:0]),
    .tag_i   (tag_w),
    .tid_i   (tid_w),
    .busy_o  (srch_busy),
    .done_o  (srch_done),
    .hit_o   (srch_hit),
    .idx_o   (srch_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pid_q   <= '0;
      zpr_q   <= '0;
      tlbx_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q   <= acc.err;
      rdata_q <= '0;
      if (acc.rd) begin
        case (rnum_i)
          RN_PID:  rdata_q <= pid_q;
          RN_ZPR:  rdata_q <= zpr_q;
          RN_TLBX: rdata_q <= tlbx_q;
          RN_LO:   rdata_q <= ext_i ? lo_w[sel][63:32] : lo_w[sel][31:0];
          RN_HI: begin
            rdata_q <= tag_w[sel];
            pid_q   <= {24'd0, tid_w[sel]};
          end
          default: rdata_q <= '0;
        endcase
      end
      if (acc.wr_pid)  pid_q <= wdata_i;
      if (acc.wr_zpr)  zpr_q <= wdata_i;
      if (acc.wr_tlbx) tlbx_q[30:0] <= wdata_i[30:0];
      if (srch_done) begin
        if (srch_hit) tlbx_q <= 32'(srch_idx);
        else          tlbx_q[MISS_BIT] <= 1'b1;
      end
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
  assign busy_o  = srch_busy;
endmodule

// File: rtl/mmu_sreg_chk.sv
`timescale 1ns/1ps
module mmu_sreg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  tlb_lvl_i,
  input logic        req_i,
  input logic        we_i,
  input logic        ext_i,
  input logic [2:0]  rnum_i,
  input logic [31:0] rdata_o,
  input logic        err_o,
  input logic        busy_o,
  input logic [31:0] tlbx_q,
  input logic        srch_done
);
  // R11
  err_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == 32'd0);

  // R10
  lvl0_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && tlb_lvl_i == 2'd0) |=> err_o);

  // R3
  ext_misuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ext_i && rnum_i != 3'd3) |=> err_o);

  // R9
  sx_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && rnum_i == 3'd5) |=> err_o);

  // R8
  busy_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);

  // R8
  busy_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |=> !busy_o);

  // R8
  busy_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && busy_o) |=> err_o);

  // R6
  miss_bit_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tlbx_q[31]) |-> $past(srch_done));
endmodule

bind mmu_sreg_bank mmu_sreg_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tlb_lvl_i (tlb_lvl_i),
  .req_i     (req_i),
  .we_i      (we_i),
  .ext_i     (ext_i),
  .rnum_i    (rnum_i),
  .rdata_o   (rdata_o),
  .err_o     (err_o),
  .busy_o    (busy_o),
  .tlbx_q    (tlbx_q),
  .srch_done (srch_done)
);

// File: tb/tb_mmu_sreg_bank.sv
`timescale 1ns/1ps
module tb_mmu_sreg_bank;
  localparam int N = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  tlb_lvl_i = 2'd3;
  logic        req_i = 1'b0, we_i = 1'b0, ext_i = 1'b0;
  logic [2:0]  rnum_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_o, busy_o;

  always #10 clk_i = ~clk_i;

  mmu_sreg_bank #(.N_ENT(N)) dut (.*);

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  logic [31:0] m_pid, m_zpr, m_tlbx;
  logic [31:0] m_tag [N];
  logic [63:0] m_lo  [N];
  logic [7:0]  m_tid [N];

  task automatic chk(input bit ok, input string tg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  function automatic logic [31:0] pmask(input logic [2:0] s);
    return ~((32'd1024 << (2 * s)) - 32'd1);
  endfunction

  function automatic logic [31:0] srch_model(input logic [31:0] v);
    logic [31:0] key, m;
    key = v & 32'hFFFF_FC00;
    for (int i = 0; i < N; i++) begin
      m = pmask(m_tag[i][9:7]);
      if (m_tag[i][6] && ((key & m) == (m_tag[i] & 32'hFFFF_FC00 & m))
          && (m_tid[i] == 8'd0 || m_tid[i] == m_pid[7:0]))
        return 32'(i);
    end
    return m_tlbx | 32'h8000_0000;
  endfunction

  function automatic bit legal(input bit we, input bit ext, input logic [2:0] rn);
    if (tlb_lvl_i == 2'd0) return 1'b0;
    if (ext && rn != 3'd3) return 1'b0;
    case (rn)
      3'd0: return we ? tlb_lvl_i[1] : 1'b1;
      3'd1: return we ? tlb_lvl_i[1] : tlb_lvl_i[0];
      3'd2: return 1'b1;
      3'd3, 3'd4: return we ? 1'b1 : tlb_lvl_i[0];
      3'd5: return we ? tlb_lvl_i[1] : 1'b0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_for(input bit we, input bit ext, input logic [2:0] rn);
    if (tlb_lvl_i == 2'd0) return "R10";
    if (ext && rn != 3'd3) return "R3";
    if (rn == 3'd5) return we ? "R7" : "R9";
    if (rn > 3'd5) return "R11";
    if (rn == 3'd4) return we ? "R5" : "R4";
    if (rn == 3'd3) return "R3";
    if (rn == 3'd2) return "R6";
    return "R10";
  endfunction

  // entered and left at a falling edge
  task automatic op(input bit we, input bit ext, input logic [2:0] rn, input logic [31:0] wd, input string tg);
    bit ok;
    logic [31:0] exp_rd, nx;
    int i;
    ok = legal(we, ext, rn);
    i = int'(m_tlbx[2:0]);
    exp_rd = '0;
    if (ok && !we) begin
      case (rn)
        3'd0: exp_rd = m_pid;
        3'd1: exp_rd = m_zpr;
        3'd2: exp_rd = m_tlbx;
        3'd3: exp_rd = ext ? m_lo[i][63:32] : m_lo[i][31:0];
        3'd4: exp_rd = m_tag[i];
        default: exp_rd = '0;
      endcase
    end
    req_i = 1'b1; we_i = we; ext_i = ext; rnum_i = rn; wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; ext_i = 1'b0;
    chk(err_o == !ok, tg, 32'(err_o), 32'(!ok));
    chk(rdata_o == exp_rd, tg, rdata_o, exp_rd);
    if (ok) begin
      if (we) begin
        case (rn)
          3'd0: m_pid = wd;
          3'd1: m_zpr = wd;
          3'd2: m_tlbx = {m_tlbx[31], wd[30:0]};
          3'd3: if (ext) m_lo[i][63:32] = wd; else m_lo[i][31:0] = wd;
          3'd4: begin m_tag[i] = wd; m_tid[i] = m_pid[7:0]; end
          3'd5: begin
            nx = srch_model(wd);
            chk(busy_o == 1'b1, "R8", 32'(busy_o), 32'd1);
            // colliding request while the search runs
            req_i = 1'b1; we_i = 1'b1; rnum_i = 3'd2; wdata_i = 32'h0000_0005;
            @(negedge clk_i);
            req_i = 1'b0; we_i = 1'b0;
            chk(err_o == 1'b1, "R8", 32'(err_o), 32'd1);
            chk(busy_o == 1'b1, "R8", 32'(busy_o), 32'd1);
            @(negedge clk_i);
            chk(busy_o == 1'b0, "R8", 32'(busy_o), 32'd0);
            m_tlbx = nx;
          end
          default: ;
        endcase
      end else if (rn == 3'd4) begin
        m_pid = {24'd0, m_tid[i]};
      end
    end
  endtask

  function automatic logic [31:0] rnd_tag();
    logic [31:0] v;
    v = 32'h4000_0000 + ($urandom_range(0, 15) << 12);
    v = v | (32'($urandom_range(0, 3)) << 7);
    if ($urandom_range(0, 3) != 0) v = v | 32'h40;
    return v;
  endfunction

  task automatic rnd_op();
    bit we, ext;
    logic [2:0] rn;
    logic [31:0] wd;
    we  = ($urandom_range(0, 1) == 1);
    ext = ($urandom_range(0, 7) == 0);
    rn  = 3'($urandom_range(0, 7));
    case (rn)
      3'd0: wd = ($urandom() & 32'hFFFF_FF00) | 32'($urandom_range(0, 3));
      3'd4: wd = rnd_tag();
      3'd5: wd = 32'h4000_0000 + ($urandom_range(0, 20) << 12) + $urandom_range(0, 4095);
      default: wd = $urandom();
    endcase
    op(we, ext, rn, wd, tag_for(we, ext, rn));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_pid = '0; m_zpr = '0; m_tlbx = '0;
    for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_lo[i] = '0; m_tid[i] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(err_o == 1'b0, "R1", 32'(err_o), 32'd0);
    chk(busy_o == 1'b0, "R1", 32'(busy_o), 32'd0);
    chk(rdata_o == 32'd0, "R1", rdata_o, 32'd0);
    op(0, 0, 3'd0, 0, "R1");
    op(0, 0, 3'd2, 0, "R1");
    op(0, 0, 3'd4, 0, "R1");
    // directed entry traffic
    op(1, 0, 3'd0, 32'h0000_0005, "R10");
    op(1, 0, 3'd2, 32'h0000_0002, "R2");
    op(1, 0, 3'd4, 32'h4000_3000 | 32'h40, "R5");
    op(1, 0, 3'd3, 32'hCAFE_0001, "R3");
    op(1, 1, 3'd3, 32'hBEEF_0002, "R3");
    op(0, 0, 3'd3, 0, "R3");
    op(0, 1, 3'd3, 0, "R3");
    op(1, 0, 3'd0, 32'h0000_0009, "R10");
    op(0, 0, 3'd4, 0, "R4");
    op(0, 0, 3'd0, 0, "R4");
    op(1, 0, 3'd2, 32'hFFFF_FFF2, "R6");
    op(0, 0, 3'd2, 0, "R6");
    // search hit, priority, miss
    op(1, 0, 3'd5, 32'h4000_3123, "R7");
    op(0, 0, 3'd2, 0, "R7");
    op(1, 0, 3'd2, 32'h0000_0006, "R7");
    op(1, 0, 3'd4, 32'h4000_0000 | (32'd1 << 7) | 32'h40, "R7");
    op(1, 0, 3'd2, 32'h0000_0001, "R7");
    op(1, 0, 3'd4, 32'h4000_0000 | (32'd1 << 7) | 32'h40, "R7");
    op(1, 0, 3'd5, 32'h4000_0C00, "R7");
    op(0, 0, 3'd2, 0, "R7");
    op(1, 0, 3'd5, 32'h7000_0000, "R7");
    op(0, 0, 3'd2, 0, "R7");
    // error corners
    op(1, 1, 3'd0, 32'h1, "R3");
    op(0, 0, 3'd5, 0, "R9");
    op(0, 0, 3'd6, 0, "R11");
    op(1, 0, 3'd7, 32'h1234, "R11");
    tlb_lvl_i = 2'd1;
    op(1, 0, 3'd0, 32'h77, "R10");
    op(0, 0, 3'd0, 0, "R11");
    tlb_lvl_i = 2'd0;
    op(0, 0, 3'd0, 0, "R10");
    tlb_lvl_i = 2'd3;
    op(0, 0, 3'd0, 0, "R11");
    // random phases over all levels
    for (int p = 0; p < 5; p++) begin
      tlb_lvl_i = (p == 4) ? 2'd3 : 2'(3 - p);
      for (int k = 0; k < 400; k++) rnd_op();
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule